// File: doc/BRIEF.md
# CPU Fetch/Execute Step Controller

This controller walks a small 16-bit processor through its instruction cycle. It has five named states: S_RESET, S_FETCH1, S_FETCH2, S_EX1 and S_EX2. It takes the decoder's 17-bit control word, two instruction-class flags and the memory ready line. From these it produces the control word the datapath actually sees, plus the strobes for the memory address register, program counter, instruction register and memory port. It also raises a request to freeze the processor clock while memory is slow.

The transitions are:
- rst high returns the controller to S_RESET from any state.
- S_RESET goes to S_FETCH1 once rst is low.
- S_FETCH1 goes to S_FETCH2 unconditionally.
- S_FETCH2 waits until mem_ready is high, then goes to S_EX1.
- S_EX1 goes back to S_FETCH1 for an ordinary instruction, or for a memory access that is already ready. A memory access that is not yet ready goes to S_EX2.
- S_EX2 waits until mem_ready is high, then goes to S_FETCH1.

During fetch the controller substitutes its own control word for the decoder's. During execute it passes the decoder's word through. For a memory access it replaces only the two address-register bits.

Top module: `cpu_step_seq`

## Requirements
- R1: While rst is high at a rising edge, the next state is S_RESET. In S_RESET, cw_out is zero and every strobe output is 0.
- R2: From S_RESET with rst low, the next state is S_FETCH1.
- R3: In S_FETCH1, mar_src=1, mar_load=1, mem_en=1 and mem_rd=1. cw_out equals FETCH_CW (default 17'h0A5A0) with bit 1 set to mar_src and bit 0 set to mar_load. The next state is S_FETCH2.
- R4: In S_FETCH2 with mem_ready=0, the state holds. mar_src=1, mar_load=0, mem_en=mem_rd=1, and cw_out is FETCH_CW with bit 1 set.
- R5: In S_FETCH2 with mem_ready=1, ir_load and pc_inc are 1 for that cycle only, and the next state is S_EX1. pc_inc and ir_load are 0 in every other case.
- R6: In S_EX1, if is_ldst=0 or mem_ready=1, the next state is S_FETCH1.
- R7: In S_EX1 with is_ldst=1 and mem_ready=0, the next state is S_EX2. S_EX2 holds while mem_ready=0 and goes to S_FETCH1 when mem_ready=1.
- R8: In S_EX1/S_EX2, cw_out equals dec_cw. When is_ldst=1, bit 1 (mar_src) is forced to 0 and bit 0 (mar_load) is forced to 1 in S_EX1 and 0 in S_EX2. The mar_src/mar_load ports carry those values; for non-memory instructions both are 0.
- R9: In S_EX1/S_EX2 with is_ldst=1, mem_en=1, mem_rd=!is_store and mem_wr=is_store. With is_ldst=0 all three are 0. mem_wr is 0 outside the execute states.
- R10: clk_hold is 1 exactly in S_FETCH2 or S_EX2 while mem_ready=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_cw | input | 17 | Control word from the instruction decoder |
| is_ldst | input | 1 | Current instruction accesses memory |
| is_store | input | 1 | Memory access is a write (valid with is_ldst) |
| mem_ready | input | 1 | Memory has completed the access |
| cw_out | output | 17 | Control word to the datapath |
| mar_src | output | 1 | Address register source: 1 = program counter |
| mar_load | output | 1 | Address register latch enable |
| pc_inc | output | 1 | Program counter increment enable |
| ir_load | output | 1 | Instruction register latch enable |
| mem_en | output | 1 | Memory enable |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| clk_hold | output | 1 | Request to stop the processor clock |

## Verification
The bench runs thousands of cycles through three ready regimes: always ready, ready about a quarter of the time, and ready about three quarters of the time. Instruction class, store flag and decoder word change on every cycle. The always-ready regime shows the shortest paths, where S_EX2 is never entered. The sparse regime produces long stalls in S_FETCH2 and S_EX2 and separates the hold cases from the advance cases. Reset pulses in the middle of a run show that S_RESET can be reached from any state. A model of the state sequence inside the bench predicts every output on every cycle, so a wrong transition shows up as a wrong output signature.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [2:0] {
        S_RESET  = 3'd0,
        S_FETCH1 = 3'd1,
        S_FETCH2 = 3'd2,
        S_EX1    = 3'd3,
        S_EX2    = 3'd4
    } seq_state_e;
endpackage

// File: rtl/seq_state.sv
module seq_state
    import seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       is_ldst,
    input  logic       mem_ready,
    output seq_state_e state
);
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            S_RESET:  nxt = S_FETCH1;
            S_FETCH1: nxt = S_FETCH2;
            S_FETCH2: nxt = mem_ready ? S_EX1 : S_FETCH2;
            S_EX1:    nxt = (!is_ldst || mem_ready) ? S_FETCH1 : S_EX2;
            S_EX2:    nxt = mem_ready ? S_FETCH1 : S_EX2;
            default:  nxt = S_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_RESET;
        else     state <= nxt;
    end

    // R4: fetch wait holds without ready
    p_fetch_wait_r4: assert property (@(posedge clk) disable iff (rst)
        (state == S_FETCH2 && !mem_ready) |=> state == S_FETCH2);
    // R7: unready memory access in first execute state goes to the wait state
    p_ex_wait_entry_r7: assert property (@(posedge clk) disable iff (rst)
        (state == S_EX1 && is_ldst && !mem_ready) |=> state == S_EX2);
    // R6: ordinary instruction finishes in one execute cycle
    p_ex_short_r6: assert property (@(posedge clk) disable iff (rst)
        (state == S_EX1 && !is_ldst) |=> state == S_FETCH1);
endmodule

// File: rtl/seq_drive.sv
module seq_drive
    import seq_pkg::*;
#(
    parameter int                CW_W        = 17,
    parameter int                MAR_SEL_BIT = 1,
    parameter int                MAR_LE_BIT  = 0,
    parameter logic [CW_W-1:0]   FETCH_CW    = 17'h0A5A0
) (
    input  logic            clk,
    input  logic            rst,
    input  seq_state_e      state,
    input  logic [CW_W-1:0] dec_cw,
    input  logic            is_ldst,
    input  logic            is_store,
    input  logic            mem_ready,
    output logic [CW_W-1:0] cw_out,
    output logic            mar_src,
    output logic            mar_load,
    output logic            pc_inc,
    output logic            ir_load,
    output logic            mem_en,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            clk_hold
);
    always_comb begin
        cw_out   = '0;
        mar_src  = 1'b0;
        mar_load = 1'b0;
        pc_inc   = 1'b0;
        ir_load  = 1'b0;
        mem_en   = 1'b0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        clk_hold = 1'b0;
        unique case (state)
            S_RESET: ;
            S_FETCH1: begin
                mar_src  = 1'b1;
                mar_load = 1'b1;
                mem_en   = 1'b1;
                mem_rd   = 1'b1;
                cw_out   = FETCH_CW;
                cw_out[MAR_SEL_BIT] = 1'b1;
                cw_out[MAR_LE_BIT]  = 1'b1;
            end
            S_FETCH2: begin
                mar_src  = 1'b1;
                mem_en   = 1'b1;
                mem_rd   = 1'b1;
                cw_out   = FETCH_CW;
                cw_out[MAR_SEL_BIT] = 1'b1;
                cw_out[MAR_LE_BIT]  = 1'b0;
                if (mem_ready) begin
                    pc_inc  = 1'b1;
                    ir_load = 1'b1;
                end else begin
                    clk_hold = 1'b1;
                end
            end
            S_EX1, S_EX2: begin
                cw_out = dec_cw;
                if (is_ldst) begin
                    mar_load = (state == S_EX1);
                    mem_en   = 1'b1;
                    mem_rd   = !is_store;
                    mem_wr   = is_store;
                    cw_out[MAR_SEL_BIT] = 1'b0;
                    cw_out[MAR_LE_BIT]  = (state == S_EX1);
                end
                if (state == S_EX2 && !mem_ready) clk_hold = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        // R1: quiet outputs in the reset state
        p_reset_quiet_r1: assert (state != S_RESET ||
            (cw_out == '0 && !mem_en && !mem_rd && !mem_wr && !pc_inc &&
             !ir_load && !mar_src && !mar_load && !clk_hold));
        // R9: never read and write together
        p_rd_wr_excl_r9: assert (!(mem_rd && mem_wr));
    end

    // R5: increment lasts one cycle
    p_pc_single_r5: assert property (@(posedge clk) disable iff (rst)
        pc_inc |=> !pc_inc);
    // R10: clock freeze only with memory not ready
    p_hold_needs_wait_r10: assert property (@(posedge clk) disable iff (rst)
        clk_hold |-> !mem_ready);
endmodule

// File: rtl/cpu_step_seq.sv
module cpu_step_seq
    import seq_pkg::*;
#(
    parameter int              CW_W        = 17,
    parameter int              MAR_SEL_BIT = 1,
    parameter int              MAR_LE_BIT  = 0,
    parameter logic [CW_W-1:0] FETCH_CW    = 17'h0A5A0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CW_W-1:0] dec_cw,
    input  logic            is_ldst,
    input  logic            is_store,
    input  logic            mem_ready,
    output logic [CW_W-1:0] cw_out,
    output logic            mar_src,
    output logic            mar_load,
    output logic            pc_inc,
    output logic            ir_load,
    output logic            mem_en,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            clk_hold
);
    seq_state_e state;

    seq_state u_state (
        .clk       (clk),
        .rst       (rst),
        .is_ldst   (is_ldst),
        .mem_ready (mem_ready),
        .state     (state)
    );

    seq_drive #(
        .CW_W        (CW_W),
        .MAR_SEL_BIT (MAR_SEL_BIT),
        .MAR_LE_BIT  (MAR_LE_BIT),
        .FETCH_CW    (FETCH_CW)
    ) u_drive (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .dec_cw    (dec_cw),
        .is_ldst   (is_ldst),
        .is_store  (is_store),
        .mem_ready (mem_ready),
        .cw_out    (cw_out),
        .mar_src   (mar_src),
        .mar_load  (mar_load),
        .pc_inc    (pc_inc),
        .ir_load   (ir_load),
        .mem_en    (mem_en),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .clk_hold  (clk_hold)
    );

    // R2: leaving reset always starts a fetch
    p_reset_exit_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_RESET) |=> (mar_load && mar_src && mem_rd));
endmodule

// File: tb/cpu_step_seq_tb.sv
`timescale 1ns/1ps
module cpu_step_seq_tb;
    localparam int NCYC = 3000;
    localparam logic [16:0] FCW = 17'h0A5A0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [16:0] dec_cw = '0;
    logic        is_ldst = 1'b0, is_store = 1'b0, mem_ready = 1'b0;
    logic [16:0] cw_out;
    logic        mar_src, mar_load, pc_inc, ir_load, mem_en, mem_rd, mem_wr, clk_hold;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cpu_step_seq u_dut (
        .clk(clk), .rst(rst), .dec_cw(dec_cw), .is_ldst(is_ldst),
        .is_store(is_store), .mem_ready(mem_ready), .cw_out(cw_out),
        .mar_src(mar_src), .mar_load(mar_load), .pc_inc(pc_inc),
        .ir_load(ir_load), .mem_en(mem_en), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .clk_hold(clk_hold)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // expected-state model: 0 reset, 1 fetch1, 2 fetch2, 3 ex1, 4 ex2
    int    es = 0;
    string ttag = "R1";

    initial begin
        logic [16:0] e_cw;
        logic e_ms, e_ml, e_pc, e_ir, e_en, e_rd, e_wr, e_h;
        string ftag;
        void'($urandom(32'd11));
        for (int i = 0; i < NCYC; i++) begin
            @(negedge clk);
            rst = (i < 3) || ((i % 500) == 250) || ((i % 500) == 251);
            dec_cw   = 17'($urandom);
            is_ldst  = $urandom % 2;
            is_store = $urandom % 2;
            case ((i / 300) % 3)
                0:       mem_ready = 1'b1;
                1:       mem_ready = ($urandom % 4) == 0;
                default: mem_ready = ($urandom % 4) != 0;
            endcase
            #1;
            e_cw = '0; e_ms = 0; e_ml = 0; e_pc = 0; e_ir = 0;
            e_en = 0; e_rd = 0; e_wr = 0; e_h = 0;
            case (es)
                1: begin e_ms = 1; e_ml = 1; e_en = 1; e_rd = 1;
                         e_cw = FCW | 17'h3; ftag = "R3"; end
                2: begin e_ms = 1; e_en = 1; e_rd = 1;
                         e_cw = (FCW & ~17'h3) | 17'h2;
                         e_pc = mem_ready; e_ir = mem_ready; e_h = !mem_ready;
                         ftag = mem_ready ? "R5" : "R4"; end
                3, 4: begin
                    e_cw = dec_cw;
                    if (is_ldst) begin
                        e_ml = (es == 3);
                        e_cw = {dec_cw[16:2], 1'b0, e_ml};
                        e_en = 1; e_rd = !is_store; e_wr = is_store;
                    end
                    e_h = (es == 4) && !mem_ready;
                    ftag = "R8";
                end
                default: ftag = "R1";
            endcase
            chk(ttag, "signature",
                {15'd0, cw_out, mar_src, mar_load, pc_inc, ir_load, mem_en, mem_rd, mem_wr, clk_hold},
                {15'd0, e_cw, e_ms, e_ml, e_pc, e_ir, e_en, e_rd, e_wr, e_h});
            chk(ftag, "cw_out", 32'(cw_out), 32'(e_cw));
            chk(ftag, "mar_src/mar_load", {30'd0, mar_src, mar_load}, {30'd0, e_ms, e_ml});
            chk((es == 0) ? "R1" : "R5", "pc_inc/ir_load", {30'd0, pc_inc, ir_load}, {30'd0, e_pc, e_ir});
            chk((es >= 3) ? "R9" : ftag, "mem_en/rd/wr", {29'd0, mem_en, mem_rd, mem_wr}, {29'd0, e_en, e_rd, e_wr});
            chk("R10", "clk_hold", 32'(clk_hold), 32'(e_h));
            @(posedge clk);
            if (rst) begin ttag = "R1"; es = 0; end
            else begin
                case (es)
                    0: begin ttag = "R2"; es = 1; end
                    1: begin ttag = "R3"; es = 2; end
                    2: begin ttag = mem_ready ? "R5" : "R4"; es = mem_ready ? 3 : 2; end
                    3: begin
                        if (!is_ldst || mem_ready) begin ttag = "R6"; es = 1; end
                        else begin ttag = "R7"; es = 4; end
                    end
                    default: begin ttag = "R7"; es = mem_ready ? 1 : 4; end
                endcase
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * (NCYC + 200));
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule